// File: doc/BRIEF.md
# Dual-Clock Nibble-to-Byte Lane FIFO

This block is a very shallow FIFO placed between a fast capture clock on the I/O side and a slower fabric clock. On every accepted write it takes one 4-bit nibble for each of several parallel lanes. The read side returns either one nibble or one byte per lane. A static width mode, captured just after reset, chooses between them. In nibble mode twelve lanes pass straight through. In byte mode ten lanes are active, and each stored entry packs two consecutive nibbles from every lane.

The array holds eight 96-bit entries, which is 768 bits. A nibble holding register sits in front of the array and a registered read output sits behind it. Both clocks are free-running and unrelated. Each domain sees the other's pointer only through a gray-coded, two-flop synchronized copy. For that reason `full` may assert early and `empty` may deassert late, but neither is ever wrong in the unsafe direction. A write while full and a read while empty are dropped.

Top module: `ififo_top`

## Requirements
- R1: With the mode captured as 0 (nibble mode), each accepted write stores the 48-bit `wr_data` as one entry. Lane i occupies bits [4i+3:4i]. A later accepted read returns that entry on `rd_data` with bits [95:48] zero, and entries come out in write order.
- R2: With the mode captured as 1 (byte mode), two consecutive accepted writes form one entry. For lane i (0..9), the first nibble goes to `rd_data` bits [8i+3:8i] and the second to [8i+7:8i+4]. `wr_data` bits [47:40] and `rd_data` bits [95:80] are not used (the latter read as zero).
- R3: The array stores exactly 8 entries. After writes stop and both clocks run for a few cycles, `full` is 1 exactly when 8 entries are unread and `empty` is 1 exactly when none are. `empty` never reads 0 while no data is stored.
- R4: The write and read pointers crossing between domains change by at most one bit per clock edge of their own domain.
- R5: A write presented while `full` is 1 and a read presented while `empty` is 1 are ignored, and the matching pointer stays unchanged.
- R6: `rd_data` changes only on the `rclk` edge that accepts a read, where it takes the entry read. Otherwise it holds its value.
- R7: While `rst_n` is low (asynchronous, both domains), `empty` is 1, `full` is 0 and `rd_data` is zero.
- R8: `byte_mode` is captured on the first `wclk` edge after reset is released. Changing it later has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side (capture) clock |
| rclk | input | 1 | Read-side (fabric) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| byte_mode | input | 1 | 0 = one nibble per lane out, 1 = one byte per lane out |
| wr_en | input | 1 | Write request, sampled on `wclk` |
| wr_data | input | 48 | One nibble per lane, lane i at [4i+3:4i] |
| full | output | 1 | No room for another entry (`wclk` domain) |
| rd_en | input | 1 | Read request, sampled on `rclk` |
| rd_data | output | 96 | Registered read entry |
| empty | output | 1 | No entry available (`rclk` domain) |

## Verification
A write commit and a read of the last or next-to-last entry can happen in the same instant. Each domain then judges its flag from a stale synchronized copy of the other pointer. To provoke this, long random streams run with `wclk` at 10 ns and `rclk` at 14 ns, so the relative edge phase drifts through every alignment. At these moments `full` and `empty` toggle while both ports are busy. The bench decides whether each request was accepted from the flag it observes just before the edge. It then checks every returned entry against a queue model and flags any deasserted `empty` that has no modelled data behind it.

// File: rtl/ififo_pkg.sv
package ififo_pkg;
    parameter int NIB_LANES  = 12;
    parameter int BYTE_LANES = 10;
    parameter int DEPTH      = 8;

    localparam int AW      = $clog2(DEPTH);
    localparam int PTR_W   = AW + 1;
    localparam int WR_W    = NIB_LANES * 4;
    localparam int HOLD_W  = BYTE_LANES * 4;
    localparam int ENTRY_W = NIB_LANES * 8;

    typedef logic [PTR_W-1:0]   ptr_t;
    typedef logic [ENTRY_W-1:0] entry_t;

    typedef struct packed {
        ptr_t              bin;
        ptr_t              gray;
        logic [HOLD_W-1:0] hold;
        logic              half;
        logic              byte_mode;
        logic              run;
    } wside_t;

    typedef struct packed {
        ptr_t   bin;
        ptr_t   gray;
        entry_t data;
    } rside_t;

    function automatic ptr_t to_gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/ififo_sync.sv
module ififo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/ififo_wside.sv
module ififo_wside
    import ififo_pkg::*;
(
    input  logic            wclk,
    input  logic            rst_n,
    input  logic            mode_in,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  ptr_t            rgray_sync,
    output logic            full,
    output ptr_t            wgray,
    output logic            mem_we,
    output logic [AW-1:0]   mem_waddr,
    output entry_t          mem_wdata
);
    wside_t w_d, w_q;
    logic   full_c;

    always_comb begin
        w_d       = w_q;
        full_c    = (w_q.gray == {~rgray_sync[PTR_W-1:PTR_W-2], rgray_sync[PTR_W-3:0]});
        mem_we    = 1'b0;
        mem_wdata = '0;
        if (!w_q.run) begin
            w_d.run       = 1'b1;
            w_d.byte_mode = mode_in;
        end else if (wr_en && !full_c) begin
            if (!w_q.byte_mode) begin
                mem_we    = 1'b1;
                mem_wdata = ENTRY_W'(wr_data);
            end else if (!w_q.half) begin
                w_d.hold = wr_data[HOLD_W-1:0];
                w_d.half = 1'b1;
            end else begin
                mem_we = 1'b1;
                for (int i = 0; i < BYTE_LANES; i++) begin
                    mem_wdata[8*i +: 8] = {wr_data[4*i +: 4], w_q.hold[4*i +: 4]};
                end
                w_d.half = 1'b0;
            end
            if (mem_we) begin
                w_d.bin  = w_q.bin + 1'b1;
                w_d.gray = to_gray(w_d.bin);
            end
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign full      = full_c;
    assign wgray     = w_q.gray;
    assign mem_waddr = w_q.bin[AW-1:0];
endmodule

// File: rtl/ififo_rside.sv
module ififo_rside
    import ififo_pkg::*;
(
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  ptr_t          wgray_sync,
    input  entry_t        mem_rdata,
    output logic          empty,
    output ptr_t          rgray,
    output logic [AW-1:0] mem_raddr,
    output entry_t        rd_data
);
    rside_t r_d, r_q;
    logic   empty_c;

    always_comb begin
        r_d     = r_q;
        empty_c = (r_q.gray == wgray_sync);
        if (rd_en && !empty_c) begin
            r_d.data = mem_rdata;
            r_d.bin  = r_q.bin + 1'b1;
            r_d.gray = to_gray(r_d.bin);
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign empty     = empty_c;
    assign rgray     = r_q.gray;
    assign mem_raddr = r_q.bin[AW-1:0];
    assign rd_data   = r_q.data;
endmodule

// File: rtl/ififo_top.sv
module ififo_top
    import ififo_pkg::*;
(
    input  logic               wclk,
    input  logic               rclk,
    input  logic               rst_n,
    input  logic               byte_mode,
    input  logic               wr_en,
    input  logic [WR_W-1:0]    wr_data,
    output logic               full,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               empty
);
    ptr_t          wgray, rgray, wgray_s, rgray_s;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    entry_t        mem_wdata, mem_rdata;
    entry_t        store_q [DEPTH];

    ififo_sync #(.W(PTR_W)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .din(rgray), .dout(rgray_s)
    );

    ififo_sync #(.W(PTR_W)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .din(wgray), .dout(wgray_s)
    );

    ififo_wside u_w (
        .wclk(wclk), .rst_n(rst_n), .mode_in(byte_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rgray_sync(rgray_s),
        .full(full), .wgray(wgray), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    ififo_rside u_r (
        .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en),
        .wgray_sync(wgray_s), .mem_rdata(mem_rdata),
        .empty(empty), .rgray(rgray), .mem_raddr(mem_raddr),
        .rd_data(rd_data)
    );

    always_ff @(posedge wclk) begin
        if (mem_we) store_q[mem_waddr] <= mem_wdata;
    end

    assign mem_rdata = store_q[mem_raddr];
endmodule

// File: rtl/ififo_chk.sv
module ififo_chk
    import ififo_pkg::*;
(
    input logic         wclk,
    input logic         rclk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         rd_en,
    input logic         full,
    input logic         empty,
    input ptr_t         wgray,
    input ptr_t         rgray,
    input entry_t       rd_data
);
    a_r5_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wgray));

    a_r5_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rgray));

    a_r4_wgray_step: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    a_r4_rgray_step: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    a_r6_rdata_hold: assert property (@(posedge rclk) disable iff (!rst_n)
        !(rd_en && !empty) |=> $stable(rd_data));

    a_r5_full_holds_ptr: assert property (@(posedge wclk) disable iff (!rst_n)
        !wr_en |=> $stable(wgray));

    always @(negedge wclk) begin
        if (!rst_n) begin
            a_r7_reset_flags: assert (empty && !full);
        end
    end
endmodule

bind ififo_top ififo_chk u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .full(full), .empty(empty), .wgray(wgray), .rgray(rgray), .rd_data(rd_data)
);

// File: tb/sim_ififo_top.sv
module sim_ififo_top;
    import ififo_pkg::*;

    logic            wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic            mode_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [WR_W-1:0] wr_data = '0;
    logic            full, empty;
    entry_t          rd_data;

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    ififo_top u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .byte_mode(mode_in),
        .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
    );

    int                checks = 0, fails = 0, wacc = 0;
    entry_t            mq[$];
    logic              bmode = 1'b0, mhalf = 1'b0;
    logic [HOLD_W-1:0] mhold = '0;

    task automatic chk(bit ok, string req, string what, entry_t act, entry_t exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic entry_t pack_bytes(logic [HOLD_W-1:0] lo, logic [HOLD_W-1:0] hi);
        entry_t e = '0;
        for (int i = 0; i < BYTE_LANES; i++) e[8*i +: 8] = {hi[4*i +: 4], lo[4*i +: 4]};
        return e;
    endfunction

    task automatic do_reset(bit m);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; mode_in = m;
        repeat (3) @(negedge wclk);
        chk(empty == 1'b1, "R7", "empty in reset", entry_t'(empty), entry_t'(1));
        chk(full == 1'b0, "R7", "full in reset", entry_t'(full), entry_t'(0));
        chk(rd_data == '0, "R7", "rd_data in reset", rd_data, '0);
        mq.delete(); mhalf = 1'b0; bmode = m;
        rst_n = 1'b1;
        repeat (4) @(negedge wclk);
        repeat (3) @(negedge rclk);
    endtask

    task automatic wr_stream(int n, int pct);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en   = ($urandom % 100) < pct;
            wr_data = WR_W'({$urandom, $urandom});
            if (wr_en && !full) begin
                wacc++;
                if (!bmode) mq.push_back(ENTRY_W'(wr_data));
                else if (!mhalf) begin mhold = wr_data[HOLD_W-1:0]; mhalf = 1'b1; end
                else begin mq.push_back(pack_bytes(mhold, wr_data[HOLD_W-1:0])); mhalf = 1'b0; end
            end
        end
        @(negedge wclk) wr_en = 1'b0;
    endtask

    task automatic rd_stream(int n, int pct);
        bit     pend = 0;
        entry_t exp = '0, last = rd_data;
        for (int i = 0; i <= n; i++) begin
            @(negedge rclk);
            if (pend) chk(rd_data == exp, bmode ? "R2" : "R1", "read entry", rd_data, exp);
            else      chk(rd_data == last, "R6", "rd_data hold", rd_data, last);
            last = rd_data;
            pend = 0;
            rd_en = (i < n) && (($urandom % 100) < pct);
            if (rd_en && !empty) begin
                if (mq.size() == 0) chk(1'b0, "R3", "empty low with no data", '0, '1);
                else begin exp = mq.pop_front(); pend = 1; end
            end
        end
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic flags_vs_model(string tag);
        settle();
        chk(empty == (mq.size() == 0), "R3", {tag, " empty"}, entry_t'(empty), entry_t'(mq.size() == 0));
        chk(full == (mq.size() == DEPTH), "R3", {tag, " full"}, entry_t'(full), entry_t'(mq.size() == DEPTH));
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // nibble mode: R7 reset, R3 capacity, R5 overflow ignored, R1 ordering
        do_reset(1'b0);
        wacc = 0;
        wr_stream(12, 100);
        chk(wacc == DEPTH, "R3", "nibble writes accepted", entry_t'(wacc), entry_t'(DEPTH));
        flags_vs_model("nibble filled");
        rd_stream(12, 100);
        flags_vs_model("nibble drained");
        // R5 underflow: reads while empty leave rd_data (R6) and pointer intact
        rd_stream(6, 100);
        wr_stream(1, 100);
        settle();
        rd_stream(3, 100);
        chk(mq.size() == 0, "R5", "single entry after underflow", entry_t'(mq.size()), '0);
        // concurrent random traffic, R1 and R4 under drifting clocks
        fork
            wr_stream(700, 55);
            rd_stream(900, 45);
        join
        rd_stream(40, 100);
        flags_vs_model("nibble random");

        // byte mode: R2 packing, R3 capacity in nibbles, R8 mode latch
        do_reset(1'b1);
        wacc = 0;
        wr_stream(20, 100);
        chk(wacc == 2 * DEPTH, "R3", "byte nibbles accepted", entry_t'(wacc), entry_t'(2 * DEPTH));
        flags_vs_model("byte filled");
        rd_stream(10, 100);
        flags_vs_model("byte drained");
        mode_in = 1'b0;  // R8: ignored until next reset
        fork
            wr_stream(700, 60);
            rd_stream(900, 40);
        join
        rd_stream(40, 100);
        flags_vs_model("byte random after mode change R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule